// File: doc/BRIEF.md
# Two-Level Super-Tile Address Mapper

The mapper turns a pixel coordinate into the byte offset of that pixel inside a framebuffer held in tiled form. It also chooses which of two base addresses the pixel belongs to. The smallest unit is a 4x4-pixel tile, with its pixels stored row by row. In super-tiled layouts, tiles are collected into 64x64-pixel super-tiles. Each super-tile is a row-major grid of 8 group columns by 4 group rows. Each group is 2 tiles wide and 4 tiles high, and the tiles inside a group are also stored row by row.

A two-bit mode picks one of four layouts. Bit 0 selects super-tiling. Bit 1 selects dual-pipe splitting, in which neighbouring tiles in a row alternate between two base addresses and each base only holds half of the tiles.

Each request is given as one cycle with `in_valid` high. The selected base, the pipe bit and the offset appear on registered outputs one clock later, together with `out_valid`. When no request arrives, the outputs keep their last values. In the split modes the caller keeps the pitch even, so that the parity of the tile index within a row matches the parity of the linear tile index.

Top module: `stile_addr_map`

## Requirements
- R1: After reset, `out_valid`, `out_pipe`, `out_base` and `out_offset` are all zero.
- R2: `out_valid` is high in exactly those cycles that follow a cycle in which `in_valid` was high at the clock edge.
- R3: When `in_valid` is low at an edge, `out_base`, `out_offset` and `out_pipe` keep their previous values.
- R4: The in-tile part of the offset is (4*(y mod 4) + (x mod 4)) * B. Here B is 2 bytes when `bpp4`=0 and 4 bytes when `bpp4`=1. A tile occupies 16*B bytes.
- R5: In mode 0 (plain tiles), the tile index is (y/4)*pitch + x/4, and the offset is index*16*B plus the in-tile part. The pitch counts tiles.
- R6: In mode 1 (super-tiles), the super-tile index is (y/64)*pitch + x/64, with the pitch counting super-tiles. The tile number inside the super-tile is gy*64 + gx*8 + iy*2 + ix, where gy = (y mod 64)/16, gx = (x mod 64)/8, iy = (y/4) mod 4 and ix = (x/4) mod 2. The tile index is super-index*256 + tile number, and the offset is that index*16*B plus the in-tile part. One super-tile therefore spans 4096*B bytes.
- R7: In modes 2 and 3 (split versions of modes 0 and 1), a pixel whose tile column x/4 is odd gets `out_base`=`base1` and `out_pipe`=1. All other pixels get `base0` and `out_pipe`=0. Modes 0 and 1 always use `base0` with `out_pipe`=0.
- R8: In modes 2 and 3, the offset is floor(T/2)*16*B plus the in-tile part. T is the tile index that mode 0 or mode 1 respectively would compute.
- R9: Within one super-tile, mode 1 gives every pixel a different offset, and mode 3 gives every pixel a different (pipe, offset) pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| x | input | XW | Pixel column |
| y | input | YW | Pixel row |
| bpp4 | input | 1 | 0: 2 bytes per pixel, 1: 4 bytes per pixel |
| pitch | input | PW | Surface width in tiles (modes 0, 2) or super-tiles (modes 1, 3) |
| mode | input | 2 | bit0 super-tiled, bit1 split |
| base0 | input | AW | Base address of pipe 0 |
| base1 | input | AW | Base address of pipe 1 |
| out_valid | output | 1 | Result valid |
| out_base | output | AW | Selected base address |
| out_offset | output | AW | Byte offset from the selected base |
| out_pipe | output | 1 | Selected pipe |

## Verification
The bench builds the mapper with 10-bit coordinates and a 6-bit pitch. This makes a complete sweep of one 64x64 super-tile cheap: every pixel is checked in all four modes and both pixel sizes. That sweep also covers the uniqueness of offsets inside a super-tile, which is checked with a per-offset occupancy map. A coarse strided sweep over the whole 1024x1024 coordinate space, using several even pitches, then exercises super-tile and tile-row crossings and the upper coordinate bits. Back-to-back requests followed by idle cycles expose the valid timing and the hold behaviour.

// File: rtl/stile_addr_map.sv
module stile_addr_map #(
  parameter int XW = 16,
  parameter int YW = 16,
  parameter int PW = 12,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  input  logic          bpp4,
  input  logic [PW-1:0] pitch,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] base0,
  input  logic [AW-1:0] base1,
  output logic          out_valid,
  output logic [AW-1:0] out_base,
  output logic [AW-1:0] out_offset,
  output logic          out_pipe
);

  localparam int IW = PW + YW + 1;

  logic [IW-1:0] row_tiles, plain_idx, super_idx, nest_idx, tile_idx, tile_eff;
  logic [7:0]    in_super;
  logic [AW-1:0] intra, offset_n;
  logic          odd_col, split, pipe_n;

  assign row_tiles = IW'(y[YW-1:2]) * IW'(pitch);
  assign plain_idx = row_tiles + IW'(x[XW-1:2]);
  assign super_idx = IW'(y[YW-1:6]) * IW'(pitch) + IW'(x[XW-1:6]);
  assign in_super  = {y[5:4], x[5:3], y[3:2], x[2]};
  assign nest_idx  = (super_idx << 8) | IW'(in_super);
  assign tile_idx  = mode[0] ? nest_idx : plain_idx;

  assign split    = mode[1];
  assign odd_col  = x[2];
  assign pipe_n   = split & odd_col;
  assign tile_eff = split ? (tile_idx >> 1) : tile_idx;

  assign intra    = AW'({y[1:0], x[1:0]}) << (bpp4 ? 2 : 1);
  assign offset_n = (AW'(tile_eff) << (bpp4 ? 6 : 5)) + intra;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_base   <= '0;
      out_offset <= '0;
      out_pipe   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_base   <= pipe_n ? base1 : base0;
        out_offset <= offset_n;
        out_pipe   <= pipe_n;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_offset) && $stable(out_base) && $stable(out_pipe)));

  // R7
  nosplit_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode[1]) |=> (!out_pipe && out_base == $past(base0)));

  // R7
  split_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[1]) |=> (out_pipe == $past(x[2]) &&
                               out_base == ($past(x[2]) ? $past(base1) : $past(base0))));

  // R4
  align4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bpp4) |=> (out_offset[1:0] == 2'b00));

  // R4
  align2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bpp4) |=> (out_offset[0] == 1'b0));

endmodule

// File: tb/stile_addr_map_bench.sv
module stile_addr_map_bench;
  localparam int XW = 10, YW = 10, PW = 6, AW = 32;

  logic clk = 0, rst_n = 0, in_valid = 0, bpp4 = 0;
  logic [XW-1:0] x = '0;
  logic [YW-1:0] y = '0;
  logic [PW-1:0] pitch = '0;
  logic [1:0] mode = '0;
  logic [AW-1:0] base0 = 32'h1000_0000, base1 = 32'h2000_0000;
  logic out_valid, out_pipe;
  logic [AW-1:0] out_base, out_offset;

  int checks = 0, fails = 0;
  bit seen [0:32767];

  always #2.5 clk = ~clk;

  stile_addr_map #(.XW(XW), .YW(YW), .PW(PW), .AW(AW)) u_stile_addr_map (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x(x), .y(y), .bpp4(bpp4),
    .pitch(pitch), .mode(mode), .base0(base0), .base1(base1),
    .out_valid(out_valid), .out_base(out_base), .out_offset(out_offset), .out_pipe(out_pipe));

  function automatic longint model_off(int px, int py, int b4, int p, int m);
    longint bb = b4 ? 4 : 2;
    longint t, sidx, ins;
    if (m % 2 == 0) t = (py / 4) * p + px / 4;
    else begin
      sidx = (py / 64) * p + px / 64;
      ins = ((py % 64) / 16) * 64 + ((px % 64) / 8) * 8 + ((py / 4) % 4) * 2 + (px / 4) % 2;
      t = sidx * 256 + ins;
    end
    if (m >= 2) t = t / 2;
    return (t * 16 * bb + (4 * (py % 4) + px % 4) * bb) % 64'h1_0000_0000;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_one(int px, int py, int b4, int p, int m, bit track);
    longint eo;
    int ep;
    x = XW'(px); y = YW'(py); bpp4 = b4[0]; pitch = PW'(p); mode = 2'(m); in_valid = 1;
    @(negedge clk);
    eo = model_off(px, py, b4, p, m);
    ep = (m >= 2) ? ((px / 4) % 2) : 0;
    check(out_valid == 1'b1, "R2", longint'(out_valid), 1);
    check(out_offset == eo[31:0], (m == 0) ? "R5/R4" : (m == 1) ? "R6/R4" : "R8/R4",
          longint'(out_offset), eo);
    check(out_pipe == ep[0] && out_base == (ep ? base1 : base0), "R7",
          longint'(out_base), ep ? longint'(base1) : longint'(base0));
    if (track) begin
      int key = {16'(0), out_pipe, out_offset[13:0]};
      check(!seen[key], "R9", longint'(key), -1);
      seen[key] = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] hb, ho;
    logic hp;
    repeat (3) @(negedge clk);
    // R1
    check(out_valid == 0 && out_base == 0 && out_offset == 0 && out_pipe == 0, "R1",
          longint'(out_offset), 0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0, "R2", longint'(out_valid), 0);

    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 2; b++) begin
        for (int k = 0; k < 32768; k++) seen[k] = 0;
        for (int py = 0; py < 64; py++)
          for (int px = 0; px < 64; px++)
            run_one(px, py, b, (m % 2) ? 2 : 16, m, (m % 2) == 1 && b == 1);
      end

    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 2; b++)
        for (int py = 0; py < 1024; py += 17)
          for (int px = 0; px < 1024; px += 11)
            run_one(px, py, b, (m % 2) ? 16 : 62, m, 0);

    in_valid = 0;
    hb = out_base; ho = out_offset; hp = out_pipe;
    x = 10'h3ff; y = 10'h3ff; mode = 2'd3; bpp4 = 1;
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 0, "R2", longint'(out_valid), 0);
      check(out_base == hb && out_offset == ho && out_pipe == hp, "R3",
            longint'(out_offset), longint'(ho));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule